// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot keeps a virtual page number, a physical frame number, an address-space tag and two status bits: one records that the page has been referenced, the other that it has been written. A lookup presents a virtual address and says whether the access is a read or a write. One cycle later the block returns either the physical address or a single fault code. Software handles every fault. It walks its own tables, installs translations through the fill port, or sets the status bits by refilling the slot, and then retries the access.

Matching uses a current-space register as well as the page number, so two processes can hold the same virtual page side by side. A context switch only needs a write to that register. Two flush inputs remove stale translations: one clears everything, the other clears only the slots of one space. When every slot holds a valid translation, a fill replaces the least recently used one.

Top module: `asid_tlb`

## Requirements
- R1: A lookup (`lk_valid` high) gives `rsp_valid` high on the next cycle. On a hit without fault, `rsp_fault` is 0 and `rsp_paddr` is the stored frame number in bits 31:12, joined to bits 11:0 of `lk_vaddr`. When no lookup is presented, `rsp_valid` is low and `rsp_fault` and `rsp_paddr` are 0. After reset `rsp_valid` is low.
- R2: When no valid slot matches, `rsp_fault` is 1 (miss) and `rsp_paddr` is 0. Miss outranks every other fault.
- R3: A slot matches only if its page number equals `lk_vaddr[31:12]` and its tag equals the current-space register. The register is loaded from `asid_in` when `asid_load` is high and takes effect from the next cycle.
- R4: A matching slot whose referenced bit is clear gives `rsp_fault` = 2 for reads and for writes, with `rsp_paddr` 0. This fault outranks the written-bit fault.
- R5: A write that matches a slot whose referenced bit is set and whose written bit is clear gives `rsp_fault` = 3 with `rsp_paddr` 0. A read of the same slot hits without fault.
- R6: A fill whose page and tag are not already present goes into the lowest-numbered invalid slot while any slot is invalid, so no valid translation is lost.
- R7: With all slots valid, a fill evicts the least recently used slot. Every matching lookup, faulting or not, and every fill marks its slot most recently used.
- R8: `flush_all` invalidates every slot in one cycle and suppresses a fill presented in the same cycle.
- R9: `flush_asid_en` invalidates only the slots whose tag equals `flush_asid_val`. Other slots keep hitting.
- R10: Loading a new current space invalidates nothing. Switching back makes the earlier translations hit again.
- R11: A fill whose page and tag match an existing valid slot overwrites that slot, so no lookup ever matches more than one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_load | input | 1 | Load the current-space register |
| asid_in | input | 8 | New current-space value |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_asid | input | 8 | Address-space tag to install |
| fill_acc | input | 1 | Referenced bit to install |
| fill_dirty | input | 1 | Written bit to install |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate slots of one space |
| flush_asid_val | input | 8 | Space tag to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 referenced, 3 written |

## Verification
Properties in the RTL check on every cycle that at most one slot matches, that the recency ages always keep a single oldest slot, that each lookup produces exactly one response a cycle later with the page offset carried through, that a written-bit fault only follows a write, and that a full flush leaves no valid slot. Which slot a fill replaces, whether a flush by space spares the other spaces, and whether a space switch keeps older translations can only be seen through the bench's ordered sequences of fills, flushes and lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_ACC   = 2'd2,
    FLT_DIRTY = 2'd3
  } tlb_fault_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N-1:0]                valid_vec,
  input  logic [N-1:0][VPN_W-1:0]     tag_vpn,
  input  logic [N-1:0][ASID_W-1:0]    tag_asid,
  input  logic [VPN_W-1:0]            key_vpn,
  input  logic [ASID_W-1:0]           key_asid,
  output logic [N-1:0]                hit_vec,
  output logic                        hit_any,
  output logic [IW-1:0]               hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (tag_vpn[g] == key_vpn) &&
                        (tag_asid[g] == key_asid);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  // R11: in-place overwrite keeps translations unique
  assert_single_match_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid_vec,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age_q;
  logic [N-1:0]         oldest_vec;
  logic                 have_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)            age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    have_free  = 1'b0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_vec[i]) begin
        victim_idx = IW'(i);
        have_free  = 1'b1;
      end
    if (!have_free)
      for (int i = 0; i < N; i++)
        if (oldest_vec[i]) victim_idx = IW'(i);
  end

  // R7: ages remain a permutation with exactly one oldest slot
  assert_unique_oldest_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      asid_load,
  input  logic [ASID_W-1:0]         asid_in,
  input  logic                      lk_valid,
  input  logic [VPN_W+OFS_W-1:0]    lk_vaddr,
  input  logic                      lk_write,
  input  logic                      fill_en,
  input  logic [VPN_W-1:0]          fill_vpn,
  input  logic [PFN_W-1:0]          fill_pfn,
  input  logic [ASID_W-1:0]         fill_asid,
  input  logic                      fill_acc,
  input  logic                      fill_dirty,
  input  logic                      flush_all,
  input  logic                      flush_asid_en,
  input  logic [ASID_W-1:0]         flush_asid_val,
  output logic                      rsp_valid,
  output logic [PFN_W+OFS_W-1:0]    rsp_paddr,
  output logic [1:0]                rsp_fault
);
  import tlb_pkg::*;

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W = PFN_W + OFS_W;

  logic [ENTRIES-1:0]              valid_q, valid_nxt;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0]              acc_q, dirty_q;
  logic [ASID_W-1:0]               cur_asid_q;

  logic [ENTRIES-1:0] lk_hit_vec, fl_hit_vec;
  logic               lk_hit, fl_hit;
  logic [IW-1:0]      lk_idx, fl_idx, victim_idx, fill_idx;
  logic               fill_do, touch_en;
  logic [IW-1:0]      touch_idx;
  tlb_fault_e         fault_c;
  logic [PA_W-1:0]    paddr_c;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .clk(clk), .rst(rst), .valid_vec(valid_q), .tag_vpn(vpn_q),
    .tag_asid(asid_q), .key_vpn(lk_vaddr[VPN_W+OFS_W-1:OFS_W]),
    .key_asid(cur_asid_q), .hit_vec(lk_hit_vec), .hit_any(lk_hit),
    .hit_idx(lk_idx));

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .clk(clk), .rst(rst), .valid_vec(valid_q), .tag_vpn(vpn_q),
    .tag_asid(asid_q), .key_vpn(fill_vpn), .key_asid(fill_asid),
    .hit_vec(fl_hit_vec), .hit_any(fl_hit), .hit_idx(fl_idx));

  assign fill_do  = fill_en && !flush_all;
  assign fill_idx = fl_hit ? fl_idx : victim_idx;
  assign touch_en = fill_do || (lk_valid && lk_hit);
  assign touch_idx = fill_do ? fill_idx : lk_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_q), .victim_idx(victim_idx));

  always_comb begin
    valid_nxt = valid_q;
    if (flush_all) begin
      valid_nxt = '0;
    end else begin
      if (flush_asid_en)
        for (int i = 0; i < ENTRIES; i++)
          if (asid_q[i] == flush_asid_val) valid_nxt[i] = 1'b0;
      if (fill_do) valid_nxt[fill_idx] = 1'b1;
    end
  end

  always_comb begin
    if (!lk_hit)                          fault_c = FLT_MISS;
    else if (!acc_q[lk_idx])              fault_c = FLT_ACC;
    else if (lk_write && !dirty_q[lk_idx]) fault_c = FLT_DIRTY;
    else                                  fault_c = FLT_NONE;
    paddr_c = (fault_c == FLT_NONE) ? {pfn_q[lk_idx], lk_vaddr[OFS_W-1:0]}
                                    : '0;
  end

  // Slot payload: written only by fills, no reset needed
  always_ff @(posedge clk) begin
    if (fill_do) begin
      vpn_q[fill_idx]   <= fill_vpn;
      pfn_q[fill_idx]   <= fill_pfn;
      asid_q[fill_idx]  <= fill_asid;
      acc_q[fill_idx]   <= fill_acc;
      dirty_q[fill_idx] <= fill_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      cur_asid_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= FLT_NONE;
    end else begin
      valid_q   <= valid_nxt;
      if (asid_load) cur_asid_q <= asid_in;
      rsp_valid <= lk_valid;
      rsp_paddr <= lk_valid ? paddr_c : '0;
      rsp_fault <= lk_valid ? fault_c : FLT_NONE;
    end
  end

  // R1: one response per lookup, one cycle later
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R1: page offset passes through untranslated
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid ##1 (rsp_fault == FLT_NONE) |->
      rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0]));
  // R5: written-bit fault only for writes
  assert_dirty_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_DIRTY) |-> $past(lk_write));
  // R8: full flush empties the array in one cycle
  assert_flush_all_R8: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_q == '0));
endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        asid_load;
  logic [7:0]  asid_in;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_write;
  logic        fill_en;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0]  fill_asid;
  logic        fill_acc, fill_dirty;
  logic        flush_all, flush_asid_en;
  logic [7:0]  flush_asid_val;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst(rst), .asid_load(asid_load), .asid_in(asid_in),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_asid(fill_asid), .fill_acc(fill_acc), .fill_dirty(fill_dirty),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid_val(flush_asid_val), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  // is_fill, vpn, offset, pfn (expected pfn for lookups), asid, acc, dirty, write, expected fault
  typedef struct packed {
    logic        is_fill;
    logic [19:0] vpn;
    logic [11:0] ofs;
    logic [19:0] pfn;
    logic [7:0]  asid;
    logic        acc;
    logic        dirty;
    logic        wr;
    logic [1:0]  flt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 20'h00010, 12'h000, 20'hAAAAA, 8'd1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{1'b1, 20'h00020, 12'h000, 20'hBBBBB, 8'd1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 20'h00030, 12'h000, 20'hCCCCC, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 20'h00010, 12'h000, 20'h12345, 8'd2, 1'b1, 1'b1, 1'b0, 2'd0},
    '{1'b0, 20'h00010, 12'hABC, 20'hAAAAA, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 20'h00010, 12'hFFF, 20'hAAAAA, 8'd0, 1'b0, 1'b0, 1'b1, 2'd0},
    '{1'b0, 20'h00020, 12'h001, 20'hBBBBB, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 20'h00020, 12'h001, 20'h00000, 8'd0, 1'b0, 1'b0, 1'b1, 2'd3},
    '{1'b0, 20'h00030, 12'h000, 20'h00000, 8'd0, 1'b0, 1'b0, 1'b1, 2'd2},
    '{1'b0, 20'h00030, 12'h000, 20'h00000, 8'd0, 1'b0, 1'b0, 1'b0, 2'd2},
    '{1'b0, 20'h00040, 12'h000, 20'h00000, 8'd0, 1'b0, 1'b0, 1'b0, 2'd1}
  };

  task automatic idle_inputs();
    asid_load = 0; asid_in = 0; lk_valid = 0; lk_vaddr = 0; lk_write = 0;
    fill_en = 0; fill_vpn = 0; fill_pfn = 0; fill_asid = 0; fill_acc = 0;
    fill_dirty = 0; flush_all = 0; flush_asid_en = 0; flush_asid_val = 0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [7:0] asid, input logic a, input logic d);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_asid = asid;
    fill_acc = a; fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk);
    asid_load = 1; asid_in = a;
    @(negedge clk);
    asid_load = 0;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic wr,
                        input logic [1:0] exp_flt, input logic [31:0] exp_pa);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== exp_flt || rsp_paddr !== exp_pa) begin
      failures++;
      $display("FAIL %s va=%h wr=%0d: got valid=%0d fault=%0d pa=%h, expected valid=1 fault=%0d pa=%h",
               req, va, wr, rsp_valid, rsp_fault, rsp_paddr, exp_flt, exp_pa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state of the response
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 2'd0 || rsp_paddr !== 32'd0) begin
      failures++;
      $display("FAIL R1 reset: got valid=%0d fault=%0d pa=%h, expected 0 0 0",
               rsp_valid, rsp_fault, rsp_paddr);
    end
    // R2: empty array misses
    lookup("R2 empty", 32'h0001_0000, 1'b0, 2'd1, 32'd0);

    set_asid(8'd1);
    // R1 R2 R4 R5: table of fills and lookups
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_fill)
        do_fill(VECS[i].vpn, VECS[i].pfn, VECS[i].asid, VECS[i].acc, VECS[i].dirty);
      else
        lookup("R1/R2/R4/R5 table", {VECS[i].vpn, VECS[i].ofs}, VECS[i].wr,
               VECS[i].flt,
               (VECS[i].flt == 2'd0) ? {VECS[i].pfn, VECS[i].ofs} : 32'd0);
    end

    // R3 R10: switch space, same page gives other frame; switch back
    set_asid(8'd2);
    lookup("R3 space 2", 32'h0001_0123, 1'b0, 2'd0, 32'h1234_5123);
    lookup("R3 space 2 no other", 32'h0002_0001, 1'b0, 2'd1, 32'd0);
    set_asid(8'd1);
    lookup("R10 back to space 1", 32'h0001_0123, 1'b0, 2'd0, 32'hAAAA_A123);

    // R11: refill same page/tag replaces in place
    do_fill(20'h00020, 20'h55555, 8'd1, 1'b1, 1'b1);
    lookup("R11 overwrite", 32'h0002_0010, 1'b1, 2'd0, 32'h5555_5010);

    // R8: flush all together with a fill; fill is dropped
    @(negedge clk);
    flush_all = 1; fill_en = 1; fill_vpn = 20'h00050; fill_pfn = 20'h0DDDD;
    fill_asid = 8'd1; fill_acc = 1; fill_dirty = 1;
    @(negedge clk);
    flush_all = 0; fill_en = 0;
    lookup("R8 flushed", 32'h0001_0000, 1'b0, 2'd1, 32'd0);
    lookup("R8 fill suppressed", 32'h0005_0000, 1'b0, 2'd1, 32'd0);

    // R6 R7 R9: fill all slots, age, flush one space, refill
    for (int k = 0; k < 7; k++)
      do_fill(20'h00100 + 20'(k), 20'h0A000 + 20'(k), 8'd1, 1'b1, 1'b1);
    do_fill(20'h00107, 20'h0A007, 8'd3, 1'b1, 1'b1);
    lookup("R7 touch oldest", 32'h0010_0004, 1'b0, 2'd0, 32'h0A00_0004);
    @(negedge clk);
    flush_asid_en = 1; flush_asid_val = 8'd3;
    @(negedge clk);
    flush_asid_en = 0;
    set_asid(8'd3);
    lookup("R9 space 3 flushed", 32'h0010_7000, 1'b0, 2'd1, 32'd0);
    set_asid(8'd1);
    do_fill(20'h00300, 20'h0B300, 8'd1, 1'b1, 1'b1);
    do_fill(20'h00200, 20'h0B200, 8'd1, 1'b1, 1'b1);
    lookup("R7 lru evicted", 32'h0010_1000, 1'b0, 2'd1, 32'd0);
    lookup("R6 free slot used first", 32'h0010_2008, 1'b0, 2'd0, 32'h0A00_2008);
    lookup("R9 other space kept", 32'h0010_6000, 1'b0, 2'd0, 32'h0A00_6000);
    lookup("R7 touched kept", 32'h0010_0000, 1'b0, 2'd0, 32'h0A00_0000);
    lookup("R6 refill present", 32'h0030_0abc, 1'b1, 2'd0, 32'h0B30_0abc);
    lookup("R7 new fill present", 32'h0020_0001, 1'b0, 2'd0, 32'h0B20_0001);

    // R1: idle cycle gives no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle: got valid=%0d expected 0", rsp_valid);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule